// File: doc/BRIEF.md
# Connection Memory Block Initializer

This block fills a whole switching connection memory with one uniform word without the host writing each location. Once the global block-fill enable is high and the host writes the fill trigger bit to one, a sweep engine walks every address of the 2048 x 16 memory. Each word gets a 5-bit host-chosen pattern in its upper field (bits 15..11) and zeros in its lower 11 bits. When the last address has been written, the trigger bit clears itself and a one-cycle completion pulse is raised.

The sweep writes on every second cycle, leaving the other slot free for the switching read path. A full pass therefore takes two cycles per word, which fits inside two frames when a frame is as many cycles as the memory has words. While the sweep runs, host writes to the memory are dropped and a busy flag is raised. Dropping the enable in the middle of a sweep aborts it at once. A simple memory model with a registered read port is included so that the results can be seen at the ports.

Top module: `cm_block_init`

## Requirements
- R1: After reset, `busy`, `trig_bit`, `done` and `rd_data` are all 0.
- R2: A trigger write (`trig_set`) while `blk_en` is 0 is ignored. `busy` and `trig_bit` stay 0 and no memory word changes.
- R3: A trigger write while `blk_en` is 1 and the block is idle starts a sweep. `busy` and `trig_bit` read 1 from the next cycle, and `fill_pat` is captured on that edge.
- R4: Every word written by a sweep equals {captured pattern, 11'b0}: the pattern sits in bits 15..11 and bits 10..0 are zero.
- R5: The sweep writes address k on the (2k+2)-th clock edge after the start edge. On the edge that writes the last address, `busy` and `trig_bit` drop to 0 and `done` pulses high for exactly one cycle. The whole sweep takes 2 x 2048 cycles, which is no more than two frames of `FRAME_CYCLES` cycles.
- R6: A host write (`cpu_we`) is stored when the block is idle and dropped while `busy` is 1.
- R7: If `blk_en` is 0 on an edge while busy, the sweep aborts on that edge with no write: `busy` and `trig_bit` go to 0 and `done` stays 0. Addresses not yet reached keep their old contents.
- R8: `rd_data` shows the word at `rd_addr` one clock edge after the address is presented.
- R9: A trigger write or a change of `fill_pat` during a sweep neither restarts it nor changes the pattern being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| blk_en | input | 1 | Global block-fill enable from the control register |
| trig_set | input | 1 | One-cycle write of 1 to the fill trigger bit |
| fill_pat | input | 5 | Pattern for bits 15..11 of every word |
| cpu_we | input | 1 | Host write strobe to the memory |
| cpu_addr | input | 11 | Host write address |
| cpu_wdata | input | 16 | Host write data |
| rd_addr | input | 11 | Switching read address |
| rd_data | output | 16 | Registered read data |
| trig_bit | output | 1 | Fill trigger bit; clears itself when the sweep ends |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle pulse when a sweep completes |

## Verification
The start state is due one edge after the trigger, so the bench samples at the next falling edge. Completion is due exactly 4096 edges after the start edge: the bench counts edges and checks that `busy` is still high one edge before the end, then checks that `busy` is low and `done` is high on the end edge, and that `done` is low one edge later. An abort on edge a leaves the first floor((a-1)/2) words filled, and the bench computes this itself. Read data is due one edge after the address, so each readback sets the address on a falling edge and compares on the next falling edge against a model that the bench keeps.

// File: rtl/cmbi_pkg.sv
// Package: geometry and shared types of the connection memory block initializer.
// Assumes a power-of-two memory depth and a pattern field at the top of each word.
package cmbi_pkg;
    localparam int CM_ADDR_W = 11;
    localparam int CM_DATA_W = 16;
    localparam int CM_PAT_W  = 5;

    typedef enum logic {
        FS_IDLE  = 1'b0,
        FS_SWEEP = 1'b1
    } fill_state_t;
endpackage

// File: rtl/cmbi_ctrl.sv
// Module: cmbi_ctrl
// Holds the trigger bit, the busy state and the captured pattern, and issues the
// start and done events. Assumes last_wr is high only on the cycle in which the
// final address is written.
module cmbi_ctrl
    import cmbi_pkg::*;
#(
    parameter int PAT_W        = CM_PAT_W,
    parameter int SWEEP_CYCLES = 4096,
    parameter int FRAME_CYCLES = 2048
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blk_en,
    input  logic             trig_set,
    input  logic [PAT_W-1:0] fill_pat,
    input  logic             last_wr,
    output logic             start,
    output logic             busy,
    output logic             trig_bit,
    output logic             done,
    output logic [PAT_W-1:0] pat_q
);
    localparam int LIMIT  = 2 * FRAME_CYCLES;
    localparam int CNT_W  = $clog2(LIMIT + 2);

    fill_state_t state;

    // Purpose: a start is accepted only from idle with the enable high.
    always_comb begin
        start = (state == FS_IDLE) && trig_set && blk_en;
    end

    // Purpose: state machine, trigger bit, completion pulse and pattern capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= FS_IDLE;
            trig_bit <= 1'b0;
            done     <= 1'b0;
            pat_q    <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                FS_IDLE: begin
                    if (start) begin
                        state    <= FS_SWEEP;
                        trig_bit <= 1'b1;
                        pat_q    <= fill_pat;
                    end
                end
                FS_SWEEP: begin
                    if (!blk_en) begin
                        state    <= FS_IDLE;
                        trig_bit <= 1'b0;
                    end else if (last_wr) begin
                        state    <= FS_IDLE;
                        trig_bit <= 1'b0;
                        done     <= 1'b1;
                    end
                end
                default: state <= FS_IDLE;
            endcase
        end
    end

    assign busy = (state == FS_SWEEP);

    // Purpose: checker counter measuring how long the busy phase lasts.
    logic [CNT_W-1:0] busy_len;
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_len <= '0;
        else if (busy) busy_len <= busy_len + 1'b1;
        else           busy_len <= '0;
    end

    a_r5_static_fit: assert final (SWEEP_CYCLES <= LIMIT);

    a_r3_start_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && trig_set && blk_en) |=> (busy && trig_bit));
    a_r2_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !blk_en) |=> !busy);
    a_r7_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !blk_en) |=> (!busy && !trig_bit && !done));
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !trig_bit));
    a_r5_within_frames: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_len < CNT_W'(LIMIT)));
    a_r9_pattern_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(pat_q));
endmodule

// File: rtl/cmbi_addr_gen.sv
// Module: cmbi_addr_gen
// Sweep address counter with alternate-cycle write slots. One slot in two is
// left for the switching read path. Assumes start and busy come from cmbi_ctrl.
module cmbi_addr_gen
    import cmbi_pkg::*;
#(
    parameter int ADDR_W = CM_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              busy,
    input  logic              blk_en,
    output logic [ADDR_W-1:0] addr,
    output logic              fill_we,
    output logic              last_wr
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

    logic slot;

    // Purpose: reset the counter on start, then step one address per write slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
            slot <= 1'b0;
        end else if (start) begin
            addr <= '0;
            slot <= 1'b0;
        end else if (busy && blk_en) begin
            slot <= ~slot;
            if (slot) addr <= addr + 1'b1;
        end
    end

    // Purpose: a write happens in the odd slot of a running, enabled sweep.
    always_comb begin
        fill_we = busy && blk_en && slot;
        last_wr = fill_we && (addr == LAST_ADDR);
    end

    a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_we && !last_wr) |=> (addr == $past(addr) + 1'b1));
    a_r5_slot_alternates: assert property (@(posedge clk) disable iff (!rst_n)
        fill_we |=> !fill_we);
endmodule

// File: rtl/cmbi_wr_mux.sv
// Module: cmbi_wr_mux
// Chooses the source of the memory write: the sweep during a fill, otherwise the
// host. Host writes are dropped while busy. Builds the fill word from the pattern.
module cmbi_wr_mux
    import cmbi_pkg::*;
#(
    parameter int ADDR_W = CM_ADDR_W,
    parameter int DATA_W = CM_DATA_W,
    parameter int PAT_W  = CM_PAT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              fill_we,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [PAT_W-1:0]  pat_q,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    localparam int LOW_W = DATA_W - PAT_W;

    // Purpose: route the sweep or the host onto the single memory write port.
    always_comb begin
        if (fill_we) begin
            mem_we    = 1'b1;
            mem_addr  = fill_addr;
            mem_wdata = {pat_q, {LOW_W{1'b0}}};
        end else begin
            mem_we    = cpu_we && !busy;
            mem_addr  = cpu_addr;
            mem_wdata = cpu_wdata;
        end
    end

    a_r4_low_field_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && busy) |-> (mem_wdata[LOW_W-1:0] == '0));
    a_r6_host_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cpu_we && !fill_we) |-> !mem_we);
endmodule

// File: rtl/cmbi_mem.sv
// Module: cmbi_mem
// Simple connection memory model: one write port and one registered read port.
// Memory contents have no reset; only the read register is reset.
module cmbi_mem
    import cmbi_pkg::*;
#(
    parameter int ADDR_W = CM_ADDR_W,
    parameter int DATA_W = CM_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    // Purpose: store one word per write.
    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    // Purpose: registered read for the switching path.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= store[raddr];
    end
endmodule

// File: rtl/cm_block_init.sv
// Module: cm_block_init (top)
// Connection memory block initializer: sweeps every address with
// {pattern, zeros} when enabled and triggered, and clears the trigger at the end.
// Assumes the sweep (two cycles per word) fits into two frames of FRAME_CYCLES.
module cm_block_init
    import cmbi_pkg::*;
#(
    parameter int FRAME_CYCLES = 2048
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 blk_en,
    input  logic                 trig_set,
    input  logic [CM_PAT_W-1:0]  fill_pat,
    input  logic                 cpu_we,
    input  logic [CM_ADDR_W-1:0] cpu_addr,
    input  logic [CM_DATA_W-1:0] cpu_wdata,
    input  logic [CM_ADDR_W-1:0] rd_addr,
    output logic [CM_DATA_W-1:0] rd_data,
    output logic                 trig_bit,
    output logic                 busy,
    output logic                 done
);
    localparam int DEPTH        = 1 << CM_ADDR_W;
    localparam int SWEEP_CYCLES = 2 * DEPTH;

    logic                 start;
    logic                 last_wr;
    logic                 fill_we;
    logic [CM_ADDR_W-1:0] fill_addr;
    logic [CM_PAT_W-1:0]  pat_q;
    logic                 mem_we;
    logic [CM_ADDR_W-1:0] mem_addr;
    logic [CM_DATA_W-1:0] mem_wdata;

    cmbi_ctrl #(
        .PAT_W(CM_PAT_W), .SWEEP_CYCLES(SWEEP_CYCLES), .FRAME_CYCLES(FRAME_CYCLES)
    ) i_ctrl (
        .clk(clk), .rst_n(rst_n), .blk_en(blk_en), .trig_set(trig_set),
        .fill_pat(fill_pat), .last_wr(last_wr), .start(start), .busy(busy),
        .trig_bit(trig_bit), .done(done), .pat_q(pat_q)
    );

    cmbi_addr_gen #(.ADDR_W(CM_ADDR_W)) i_addr (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .blk_en(blk_en),
        .addr(fill_addr), .fill_we(fill_we), .last_wr(last_wr)
    );

    cmbi_wr_mux #(.ADDR_W(CM_ADDR_W), .DATA_W(CM_DATA_W), .PAT_W(CM_PAT_W)) i_mux (
        .clk(clk), .rst_n(rst_n), .busy(busy), .fill_we(fill_we),
        .fill_addr(fill_addr), .pat_q(pat_q), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    cmbi_mem #(.ADDR_W(CM_ADDR_W), .DATA_W(CM_DATA_W)) i_mem (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_addr),
        .wdata(mem_wdata), .raddr(rd_addr), .rdata(rd_data)
    );

    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!busy && !trig_bit && !done));
endmodule

// File: tb/test_cm_block_init.sv
// Bench for cm_block_init: directed sweeps, aborts and seeded random host traffic.
module test_cm_block_init;
    localparam int DEPTH = 2048;
    localparam int SWEEP = 2 * DEPTH;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        blk_en = 1'b0;
    logic        trig_set = 1'b0;
    logic [4:0]  fill_pat = '0;
    logic        cpu_we = 1'b0;
    logic [10:0] cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic [10:0] rd_addr = '0;
    logic [15:0] rd_data;
    logic        trig_bit, busy, done;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_mem [DEPTH];
    int unsigned seed_dummy;

    always #10 clk = ~clk;   // 50 MHz

    cm_block_init i_cm_block_init (
        .clk(clk), .rst_n(rst_n), .blk_en(blk_en), .trig_set(trig_set),
        .fill_pat(fill_pat), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
        .trig_bit(trig_bit), .busy(busy), .done(done)
    );

    function automatic logic [15:0] fill_word(input logic [4:0] p);
        return {p, 11'b0};
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Read back every word and compare with the bench model.
    task automatic verify_all(input string req);
        for (int i = 0; i < DEPTH; i++) begin
            rd_addr = 11'(i);
            tick();
            check(32'(rd_data), 32'(exp_mem[i]), req);
        end
    endtask

    // Trigger on the next edge (E0) and check the start state; ends at negedge after E0.
    task automatic start_fill(input logic [4:0] p);
        fill_pat = p;
        trig_set = 1'b1;
        tick();
        trig_set = 1'b0;
        check(32'(busy), 1, "R3 busy");
        check(32'(trig_bit), 1, "R3 trig_bit");
    endtask

    task automatic finish_fill(input int edges_done);
        repeat (SWEEP - 1 - edges_done) @(posedge clk);
        @(negedge clk);
        check(32'(busy), 1, "R5 busy one edge before end");
        check(32'(done), 0, "R5 done early");
        tick();
        check(32'(busy), 0, "R5 busy cleared");
        check(32'(trig_bit), 0, "R5 trig_bit self-clear");
        check(32'(done), 1, "R5 done pulse");
        tick();
        check(32'(done), 0, "R5 done one cycle");
    endtask

    task automatic host_writes(input int n);
        for (int i = 0; i < n; i++) begin
            cpu_we    = 1'b1;
            cpu_addr  = 11'($urandom_range(DEPTH - 1));
            cpu_wdata = 16'($urandom);
            exp_mem[cpu_addr] = cpu_wdata;
            tick();
        end
        cpu_we = 1'b0;
    endtask

    initial begin
        seed_dummy = $urandom(32'd1234);
        repeat (3) tick();
        check(32'(busy), 0, "R1 busy");
        check(32'(trig_bit), 0, "R1 trig_bit");
        check(32'(done), 0, "R1 done");
        check(32'(rd_data), 0, "R1 rd_data");
        rst_n = 1'b1;
        tick();

        // R2: trigger with enable low is ignored.
        trig_set = 1'b1;
        tick();
        trig_set = 1'b0;
        check(32'(busy), 0, "R2 busy");
        check(32'(trig_bit), 0, "R2 trig_bit");
        repeat (4) tick();
        check(32'(busy), 0, "R2 still idle");

        // First full sweep, with mid-sweep host write, re-trigger and pattern change (R6, R9).
        blk_en = 1'b1;
        begin
            logic [4:0] p;
            p = 5'h15;
            start_fill(p);
            repeat (3000) @(posedge clk);
            @(negedge clk);
            cpu_we = 1'b1; cpu_addr = 11'd5; cpu_wdata = 16'h07FF;
            trig_set = 1'b1; fill_pat = 5'h0A;
            @(posedge clk);
            @(negedge clk);
            cpu_we = 1'b0; trig_set = 1'b0;
            check(32'(busy), 1, "R9 no restart");
            finish_fill(3001);
            for (int i = 0; i < DEPTH; i++) exp_mem[i] = fill_word(p);
            verify_all("R4 R6 R9 full sweep");
        end

        // R2 memory untouched: trigger with enable low after known contents.
        blk_en = 1'b0;
        fill_pat = 5'h03;
        trig_set = 1'b1;
        tick();
        trig_set = 1'b0;
        check(32'(busy), 0, "R2 busy after fill");
        rd_addr = 11'd100;
        tick();
        check(32'(rd_data), 32'(exp_mem[100]), "R2 memory unchanged");

        // R6 / R8: random host writes while idle, then readback.
        host_writes(300);
        for (int i = 0; i < 200; i++) begin
            rd_addr = 11'($urandom_range(DEPTH - 1));
            tick();
            check(32'(rd_data), 32'(exp_mem[rd_addr]), "R8 R6 host readback");
        end

        // R7: abort sweeps at random edges.
        blk_en = 1'b1;
        for (int k = 0; k < 3; k++) begin
            logic [4:0] p;
            int a, n;
            p = 5'($urandom);
            a = (k == 0) ? 2 : int'($urandom_range(3000, 3));
            start_fill(p);
            repeat (a - 1) @(posedge clk);
            @(negedge clk);
            blk_en = 1'b0;
            tick();
            check(32'(busy), 0, "R7 abort busy");
            check(32'(trig_bit), 0, "R7 abort trig_bit");
            check(32'(done), 0, "R7 abort no done");
            n = (a - 1) / 2;
            for (int i = 0; i < n; i++) exp_mem[i] = fill_word(p);
            verify_all("R7 partial contents");
            blk_en = 1'b1;
            host_writes(20);
        end

        // Random pattern sweeps covering the pattern extremes.
        for (int k = 0; k < 3; k++) begin
            logic [4:0] p;
            p = (k == 0) ? 5'h1F : (k == 1) ? 5'h00 : 5'($urandom);
            start_fill(p);
            finish_fill(0);
            for (int i = 0; i < DEPTH; i++) exp_mem[i] = fill_word(p);
            verify_all("R4 R5 sweep pattern");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule